// File: doc/BRIEF.md
# Ethernet MAC Control and Status Register Bank

This block is the byte-wide, host-visible register pair that configures a small Ethernet MAC and reports its state. The host reaches it through a plain synchronous bus (offset, write byte, write strobe, read strobe, registered read byte). Offset 0 holds the control byte. It sets PHY selection, wakeup enable, forced collision, duplex and loopback mode, and it starts a timed software reset. Offset 1 holds the status byte. It mirrors link, speed and receive-overflow levels and keeps sticky flags for wakeup and the two transmit slots.

A software reset is started by writing a 1 to the control reset bit. The reset output then stays high for a fixed 10 microsecond window, whose length in cycles comes from the clock frequency. The bit clears itself when the window ends. The reset returns the MAC-mode fields and transmit flags to zero. PHY selection, wakeup enable and the wakeup flag survive it. Sticky flags are cleared by a read of the status byte, by writing 1 to them, and for the wakeup flag also by turning wakeup off. A hardware event arriving in the same cycle as a clear always wins.

Top module: `macreg_bank`

## Requirements
- R1: After hardware reset every output is 0, and both the control byte (offset 0) and the status byte (offset 1) read 0x00.
- R2: A write to offset 0 stores the external-PHY select (bit 7), the wakeup enable (bit 6), the forced collision (bit 4) and the loopback mode (bits 2:1). Loopback codes are 00 none, 01 MAC loop, 10 PHY 100M digital loop and 11 reserved. These fields drive their outputs and read back at the same positions. Bit 5 always reads 0.
- R3: The duplex bit (bit 3) follows the `phy_fdx` input while the stored PHY select is 0, and writes to it are then ignored. While the stored PHY select is 1, the duplex bit is written and read like a normal bit.
- R4: Writing 1 to bit 0 of offset 0 raises `soft_rst` from the next cycle. The output stays high for exactly CLK_KHZ*SRST_US/1000 cycles (2000 with the defaults), then clears by itself. Bit 0 reads back as `soft_rst`.
- R5: Starting a software reset clears forced collision, stored duplex, loopback mode and both transmit-done flags. PHY select, wakeup enable and the wakeup flag keep their values. The other bits of the starting write are ignored.
- R6: While `soft_rst` is high, writes to offset 0 have no effect.
- R7: The status byte places speed at bit 7 (1 = 10 Mb/s, forced to 0 while the link is down), link up at bit 6, and the `rx_ovf_flag` level at bit 1. Bits 4 and 0 read 0.
- R8: Sticky flags are set as follows. A pulse on `ev_tx1_done` sets bit 2 and a pulse on `ev_tx2_done` sets bit 3. A pulse on `ev_wake` sets bit 5 only while wakeup is enabled. Each flag then stays set until it is cleared.
- R9: An accepted read of offset 1 returns the flags as they were before the read, and clears bits 5, 3 and 2 in that same cycle.
- R10: Writing offset 1 clears each of bits 5, 3 and 2 where the written byte has a 1. Bits written as 0 keep their value.
- R11: An accepted write to offset 0 with bit 6 = 0 (and bit 0 = 0) clears the wakeup flag.
- R12: A hardware event that sets a flag in the same cycle as any clear of that flag leaves the flag set.
- R13: `bus_rdata` changes only in the cycle after an accepted `bus_re` and otherwise holds its value. Offsets other than 0 and 1 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_we | input | 1 | Write strobe, accepted on the clock edge |
| bus_re | input | 1 | Read strobe, accepted on the clock edge |
| bus_rdata | output | 8 | Registered read byte |
| ev_wake | input | 1 | Wakeup event pulse |
| ev_tx1_done | input | 1 | Transmit slot 1 finished pulse |
| ev_tx2_done | input | 1 | Transmit slot 2 finished pulse |
| rx_ovf_flag | input | 1 | Receive FIFO overflow level |
| link_up | input | 1 | Link good level |
| speed_10m | input | 1 | 1 when the link runs at 10 Mb/s |
| phy_fdx | input | 1 | Duplex reported by the internal PHY |
| ctl_ext_phy | output | 1 | External PHY selected |
| ctl_wake_en | output | 1 | Wakeup function enabled |
| ctl_force_col | output | 1 | Forced collision test mode |
| ctl_fdx | output | 1 | Effective full-duplex mode |
| ctl_lpbk | output | 2 | Loopback mode code |
| soft_rst | output | 1 | Software reset in progress |

## Verification
The checker verifies on every cycle the following. The reset output rises only after a reset write and lasts exactly the configured count. Control fields hold still inside the reset window, and the reset keeps PHY select and wakeup enable while clearing the mode fields. The wakeup flag rises only on an enabled event, and a transmit event always leaves its flag set. A status read clears the flag unless an event coincides, and the reserved status bits read zero. Only the bench's scenarios show the full picture of several other behaviours: the read-back layout of each control field, duplex write masking in internal-PHY mode, write-one-to-clear with mixed masks, the wipe of the wakeup flag when wakeup is disabled, and the value held on the read bus between reads.

// File: rtl/macreg_pkg.sv
package macreg_pkg;

    localparam int unsigned OFS_CTL = 0;
    localparam int unsigned OFS_STS = 1;

    // control byte positions
    localparam int unsigned CB_EXT  = 7;
    localparam int unsigned CB_WEN  = 6;
    localparam int unsigned CB_RSVD = 5;
    localparam int unsigned CB_FCOL = 4;
    localparam int unsigned CB_FDX  = 3;
    localparam int unsigned CB_LBHI = 2;
    localparam int unsigned CB_LBLO = 1;
    localparam int unsigned CB_RST  = 0;

    // status byte positions
    localparam int unsigned SB_SPD  = 7;
    localparam int unsigned SB_LINK = 6;
    localparam int unsigned SB_WAKE = 5;
    localparam int unsigned SB_TX2  = 3;
    localparam int unsigned SB_TX1  = 2;
    localparam int unsigned SB_RXOV = 1;

    typedef enum logic [1:0] {
        LPBK_NONE = 2'b00,
        LPBK_MAC  = 2'b01,
        LPBK_PHY  = 2'b10,
        LPBK_RSVD = 2'b11
    } lpbk_e;

    typedef struct packed {
        logic  ext;
        logic  wen;
        logic  fcol;
        logic  fdx;
        lpbk_e lpbk;
    } ctl_t;

    typedef struct packed {
        logic wake;
        logic tx2;
        logic tx1;
    } sticky_t;

endpackage

// File: rtl/macreg_srst_timer.sv
module macreg_srst_timer #(
    parameter int unsigned CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int unsigned CNT_W = (CYC < 2) ? 1 : $clog2(CYC + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.cnt    = CNT_W'(CYC - 1);
            end
        end else if (st_q.cnt == '0) begin
            st_d.active = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;

endmodule

// File: rtl/macreg_ctl.sv
module macreg_ctl
    import macreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    input  logic       srst_active,
    input  logic       phy_fdx,
    output ctl_t       ctl,
    output logic       fdx_eff,
    output logic       srst_start,
    output logic       wake_wipe
);
    ctl_t ctl_d, ctl_q;
    logic accept;
    logic rsvd_unused;

    assign rsvd_unused = wdata[CB_RSVD];
    assign accept      = wr_hit && !srst_active;
    assign srst_start  = accept && wdata[CB_RST];
    assign wake_wipe   = accept && !wdata[CB_RST] && !wdata[CB_WEN];

    always_comb begin
        ctl_d = ctl_q;
        if (srst_start) begin
            ctl_d.fcol = 1'b0;
            ctl_d.fdx  = 1'b0;
            ctl_d.lpbk = LPBK_NONE;
        end else if (accept) begin
            ctl_d.ext  = wdata[CB_EXT];
            ctl_d.wen  = wdata[CB_WEN];
            ctl_d.fcol = wdata[CB_FCOL];
            ctl_d.lpbk = lpbk_e'(wdata[CB_LBHI:CB_LBLO]);
            if (ctl_q.ext)
                ctl_d.fdx = wdata[CB_FDX];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl     = ctl_q;
    assign fdx_eff = ctl_q.ext ? ctl_q.fdx : phy_fdx;

endmodule

// File: rtl/macreg_sts.sv
module macreg_sts
    import macreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rd_clr,
    input  logic    w1c_hit,
    input  sticky_t w1c_mask,
    input  logic    wake_wipe,
    input  logic    srst_start,
    input  logic    wake_en,
    input  logic    ev_wake,
    input  logic    ev_tx1,
    input  logic    ev_tx2,
    output sticky_t flags
);
    sticky_t flg_d, flg_q;
    sticky_t clr, set;

    always_comb begin
        clr = '0;
        if (rd_clr)
            clr = '1;
        if (w1c_hit)
            clr = clr | w1c_mask;
        if (wake_wipe)
            clr.wake = 1'b1;
        if (srst_start) begin
            clr.tx1 = 1'b1;
            clr.tx2 = 1'b1;
        end
        set.wake = ev_wake && wake_en;
        set.tx2  = ev_tx2;
        set.tx1  = ev_tx1;
        flg_d    = (flg_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;

endmodule

// File: rtl/macreg_bank.sv
module macreg_bank
    import macreg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CLK_KHZ = 200000,
    parameter int unsigned SRST_US = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [7:0]        bus_rdata,
    input  logic              ev_wake,
    input  logic              ev_tx1_done,
    input  logic              ev_tx2_done,
    input  logic              rx_ovf_flag,
    input  logic              link_up,
    input  logic              speed_10m,
    input  logic              phy_fdx,
    output logic              ctl_ext_phy,
    output logic              ctl_wake_en,
    output logic              ctl_force_col,
    output logic              ctl_fdx,
    output logic [1:0]        ctl_lpbk,
    output logic              soft_rst
);
    localparam int unsigned SRST_CYC = (CLK_KHZ * SRST_US) / 1000;

    logic    hit_ctl, hit_sts;
    ctl_t    ctl;
    logic    fdx_eff, srst_start, wake_wipe, srst_active;
    sticky_t flags, w1c_mask;
    logic [7:0] ctl_rd, sts_rd;
    logic [7:0] rd_d, rd_q;

    assign hit_ctl = (bus_addr == ADDR_W'(OFS_CTL));
    assign hit_sts = (bus_addr == ADDR_W'(OFS_STS));

    macreg_srst_timer #(.CYC(SRST_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (srst_start),
        .active (srst_active)
    );

    macreg_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (bus_we && hit_ctl),
        .wdata       (bus_wdata),
        .srst_active (srst_active),
        .phy_fdx     (phy_fdx),
        .ctl         (ctl),
        .fdx_eff     (fdx_eff),
        .srst_start  (srst_start),
        .wake_wipe   (wake_wipe)
    );

    assign w1c_mask.wake = bus_wdata[SB_WAKE];
    assign w1c_mask.tx2  = bus_wdata[SB_TX2];
    assign w1c_mask.tx1  = bus_wdata[SB_TX1];

    macreg_sts u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_clr     (bus_re && hit_sts),
        .w1c_hit    (bus_we && hit_sts),
        .w1c_mask   (w1c_mask),
        .wake_wipe  (wake_wipe),
        .srst_start (srst_start),
        .wake_en    (ctl.wen),
        .ev_wake    (ev_wake),
        .ev_tx1     (ev_tx1_done),
        .ev_tx2     (ev_tx2_done),
        .flags      (flags)
    );

    always_comb begin
        ctl_rd = '0;
        ctl_rd[CB_EXT]          = ctl.ext;
        ctl_rd[CB_WEN]          = ctl.wen;
        ctl_rd[CB_FCOL]         = ctl.fcol;
        ctl_rd[CB_FDX]          = fdx_eff;
        ctl_rd[CB_LBHI:CB_LBLO] = ctl.lpbk;
        ctl_rd[CB_RST]          = srst_active;

        sts_rd = '0;
        sts_rd[SB_SPD]  = link_up && speed_10m;
        sts_rd[SB_LINK] = link_up;
        sts_rd[SB_WAKE] = flags.wake;
        sts_rd[SB_TX2]  = flags.tx2;
        sts_rd[SB_TX1]  = flags.tx1;
        sts_rd[SB_RXOV] = rx_ovf_flag;

        rd_d = rd_q;
        if (bus_re) begin
            if (hit_ctl)      rd_d = ctl_rd;
            else if (hit_sts) rd_d = sts_rd;
            else              rd_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata     = rd_q;
    assign ctl_ext_phy   = ctl.ext;
    assign ctl_wake_en   = ctl.wen;
    assign ctl_force_col = ctl.fcol;
    assign ctl_fdx       = fdx_eff;
    assign ctl_lpbk      = ctl.lpbk;
    assign soft_rst      = srst_active;

endmodule

// File: rtl/macreg_bank_chk.sv
module macreg_bank_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned SRST_CYC = 2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [7:0]        bus_rdata,
    input logic              ev_wake,
    input logic              ev_tx1_done,
    input logic              ctl_ext_phy,
    input logic              ctl_wake_en,
    input logic              ctl_force_col,
    input logic [1:0]        ctl_lpbk,
    input logic              soft_rst,
    input logic [7:0]        sts_rd
);
    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_cnt <= 0;
        else if (soft_rst) hi_cnt <= hi_cnt + 1;
        else               hi_cnt <= 0;
    end

    AST_SRST_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> $past(bus_we && bus_addr == '0 && bus_wdata[0])); // R4

    AST_SRST_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= SRST_CYC); // R4

    AST_SRST_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst) |-> hi_cnt == SRST_CYC); // R4

    AST_SRST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> $stable(ctl_ext_phy) && $stable(ctl_wake_en)); // R5

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |-> !ctl_force_col && ctl_lpbk == 2'b00); // R5

    AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst && $past(soft_rst) |->
            $stable({ctl_ext_phy, ctl_wake_en, ctl_force_col, ctl_lpbk})); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && bus_addr == ADDR_W'(1)) |-> bus_rdata[4] == 1'b0 && bus_rdata[0] == 1'b0); // R7

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_rd[5]) |-> $past(ev_wake && ctl_wake_en)); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_re && bus_addr == ADDR_W'(1) && !ev_tx1_done) |-> !sts_rd[2]); // R9

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_tx1_done) |-> sts_rd[2]); // R12

endmodule

bind macreg_bank macreg_bank_chk #(.ADDR_W(ADDR_W), .SRST_CYC(SRST_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_we        (bus_we),
    .bus_re        (bus_re),
    .bus_rdata     (bus_rdata),
    .ev_wake       (ev_wake),
    .ev_tx1_done   (ev_tx1_done),
    .ctl_ext_phy   (ctl_ext_phy),
    .ctl_wake_en   (ctl_wake_en),
    .ctl_force_col (ctl_force_col),
    .ctl_lpbk      (ctl_lpbk),
    .soft_rst      (soft_rst),
    .sts_rd        (sts_rd)
);

// File: tb/test_macreg_bank.sv
module test_macreg_bank;

    localparam int unsigned SRST_CYC = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       ev_wake = 1'b0, ev_tx1_done = 1'b0, ev_tx2_done = 1'b0;
    logic       rx_ovf_flag = 1'b0, link_up = 1'b0, speed_10m = 1'b0, phy_fdx = 1'b0;
    logic       ctl_ext_phy, ctl_wake_en, ctl_force_col, ctl_fdx, soft_rst;
    logic [1:0] ctl_lpbk;

    int checks = 0;
    int failures = 0;
    int srst_cnt = 0;

    always #2.5 clk = ~clk;

    macreg_bank i_macreg_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .ev_wake(ev_wake), .ev_tx1_done(ev_tx1_done), .ev_tx2_done(ev_tx2_done),
        .rx_ovf_flag(rx_ovf_flag), .link_up(link_up), .speed_10m(speed_10m),
        .phy_fdx(phy_fdx), .ctl_ext_phy(ctl_ext_phy), .ctl_wake_en(ctl_wake_en),
        .ctl_force_col(ctl_force_col), .ctl_fdx(ctl_fdx), .ctl_lpbk(ctl_lpbk),
        .soft_rst(soft_rst)
    );

    always @(negedge clk) if (soft_rst) srst_cnt++;

    // {is_read, byte}: write byte to offset 0, or read offset 0 and expect byte
    localparam logic [8:0] VEC [12] = '{
        {1'b0, 8'h80}, {1'b1, 8'h80},
        {1'b0, 8'hDE}, {1'b1, 8'hDE},
        {1'b0, 8'h20}, {1'b1, 8'h00},
        {1'b0, 8'h08}, {1'b1, 8'h00},
        {1'b0, 8'h4C}, {1'b1, 8'h44},
        {1'b0, 8'h12}, {1'b1, 8'h12}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) ev_wake = 1'b1;
        if (which == 1) ev_tx1_done = 1'b1;
        if (which == 2) ev_tx2_done = 1'b1;
        @(negedge clk);
        ev_wake = 1'b0; ev_tx1_done = 1'b0; ev_tx2_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 outputs", {ctl_ext_phy, ctl_wake_en, ctl_force_col, ctl_fdx, ctl_lpbk, soft_rst, 1'b0}, 8'h00);
        rd(8'd0, v); check("R1 ctl read", v, 8'h00);
        rd(8'd1, v); check("R1 sts read", v, 8'h00);

        // R2 / R3 table
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][8]) begin
                rd(8'd0, v);
                check($sformatf("R2/R3 vector %0d", i), v, VEC[i][7:0]);
            end else begin
                wr(8'd0, VEC[i][7:0]);
            end
        end
        check("R2 lpbk out", {6'd0, ctl_lpbk}, 8'h01);
        check("R2 fcol out", {7'd0, ctl_force_col}, 8'h01);

        // R3 internal PHY duplex follows input
        phy_fdx = 1'b1;
        @(negedge clk);
        check("R3 fdx follows phy", {7'd0, ctl_fdx}, 8'h01);
        rd(8'd0, v); check("R3 fdx readback", v, 8'h1A);
        phy_fdx = 1'b0;

        // R7 status levels
        link_up = 1'b1; speed_10m = 1'b1; rx_ovf_flag = 1'b1;
        rd(8'd1, v); check("R7 link speed ovf", v, 8'hC2);
        link_up = 1'b0;
        rd(8'd1, v); check("R7 speed masked", v, 8'h02);
        speed_10m = 1'b0; rx_ovf_flag = 1'b0;

        // R8 / R9 tx1 sticky then cleared by read
        pulse(1);
        rd(8'd1, v); check("R8 tx1 sticky", v, 8'h04);
        rd(8'd1, v); check("R9 read cleared", v, 8'h00);

        // R8 wake ignored while disabled (wen is 0 here)
        pulse(0);
        rd(8'd1, v); check("R8 wake gated", v, 8'h00);

        // R10 write-1-to-clear
        wr(8'd0, 8'h40);
        pulse(0); pulse(2);
        wr(8'd1, 8'h08);
        rd(8'd1, v); check("R10 w1c tx2 only", v, 8'h20);
        rd(8'd1, v); check("R9 second read", v, 8'h00);
        pulse(1);
        wr(8'd1, 8'h00);
        rd(8'd1, v); check("R10 zero no effect", v, 8'h04);

        // R11 disabling wakeup wipes the flag
        pulse(0);
        wr(8'd0, 8'h00);
        rd(8'd1, v); check("R11 wake wiped", v, 8'h00);
        wr(8'd0, 8'h40);

        // R12 set wins over clear-on-read
        @(negedge clk);
        bus_addr = 8'd1; bus_re = 1'b1; ev_tx1_done = 1'b1;
        @(negedge clk);
        bus_re = 1'b0; ev_tx1_done = 1'b0;
        check("R12 pre-read value", bus_rdata, 8'h00);
        rd(8'd1, v); check("R12 set wins", v, 8'h04);

        // R13 unmapped offset and hold
        rd(8'd5, v); check("R13 unmapped", v, 8'h00);
        rd(8'd0, v); check("R13 ctl read", v, 8'h40);
        repeat (3) @(negedge clk);
        check("R13 hold", bus_rdata, 8'h40);

        // R4 / R5 / R6 soft reset
        wr(8'd0, 8'hDE);
        pulse(1); pulse(0);
        srst_cnt = 0;
        wr(8'd0, 8'h01);
        check("R4 soft_rst high", {7'd0, soft_rst}, 8'h01);
        rd(8'd0, v); check("R5 ctl during reset", v, 8'hC1);
        wr(8'd0, 8'h00);
        rd(8'd0, v); check("R6 write ignored", v, 8'hC1);
        while (soft_rst) @(negedge clk);
        check("R4 length", srst_cnt[7:0], SRST_CYC[7:0]);
        checks++;
        if (srst_cnt != SRST_CYC) begin
            failures++;
            $display("FAIL R4 length actual=%0d expected=%0d", srst_cnt, SRST_CYC);
        end
        rd(8'd0, v); check("R5 ctl after reset", v, 8'hC0);
        rd(8'd1, v); check("R5 sts after reset", v, 8'h20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule